// File: doc/BRIEF.md
# SPI Command-Then-Read Master

This block is a register-mapped SPI master that performs one chained transaction per trigger. It first shifts out a programmed number of command bytes taken from a transmit FIFO. In write-then-read mode it then shifts in a programmed number of response bytes, with no pause between the two phases, and packs them into a receive FIFO. Chip select is owned by the engine for the whole transaction.

Software talks to the block through one 32-bit data word address. A write to it loads the transmit FIFO, and a read from it drains the receive FIFO. Each word holds up to four bytes, with the first byte in the lowest lane. Other addresses give a control word with a soft reset, a transfer word, a status word, an interrupt-enable word and a clock divider. Typical use is to load the first command word, set the trigger, keep feeding words while the transmit-full flag allows, poll busy until it clears, and then read the response words.

Top module: `spi_cmdread_master`

## Requirements
- R1: The divider is at word address 4, bits 7:0, and resets to 1. Bits 31:8 read as zero and a write leaves them unaffected. Each SCLK half period lasts divider+1 bus clocks, so the SCLK period is 2*(divider+1).
- R2: The transfer word is at address 1. Bits 7:0 hold the write byte count minus one, bits 15:8 hold the read byte count minus one, and bit 16 selects the mode (0 = write-only, 1 = write-then-read). Writing bit 31 as 1 while idle starts a transaction. Bit 31 always reads as 0.
- R3: Data words written at address 5 are sent lane 0 first (bits 7:0), then lanes 1, 2 and 3. A last word may be partly used. Bits go out MSB first in SPI mode 0: SCLK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge.
- R4: CS_N goes low on the cycle after the trigger write. The read phase's first rising edge follows the last write bit's falling edge by exactly one half period. MOSI is low during the read phase. CS_N returns high together with the last falling edge. With transmit data ready in time, CS_N stays low for 1 + 16*(divider+1)*(W+R) bus clocks, where W and R are the write and read byte counts.
- R5: Received bytes are packed lane 0 first. A word is pushed after four bytes or after the last byte, and its unused upper lanes are zero. A read at address 5 pops one word. A read while the receive FIFO is empty returns 0.
- R6: The status word is at address 2. Bit 0 is busy, bit 1 is transmit-full, bit 2 is receive-empty and bit 3 is transmit-empty. Busy clears only after the final received word is already in the receive FIFO.
- R7: A data write while the transmit FIFO is full is dropped and never reaches the wire.
- R8: A write to the transfer word while busy has no effect: the fields are unchanged and no new transaction starts.
- R9: Writing 1 to bit 0 of the control word (address 0) stops the transaction and raises CS_N. It also empties both FIFOs. The divider, transfer and interrupt-enable words keep their values.
- R10: The trigger may be set after only part of the command data has been loaded. Words written during the transaction are sent in order. If the transmit FIFO runs dry mid-command, SCLK is held low until data arrives.
- R11: The interrupt-enable word is at address 3, bits 7:0, and is plain read/write storage. After reset, status reads 0xC, the transfer word reads 0 and the interrupt-enable word reads 0.
- R12: In write-only mode no bytes are received, and the receive FIFO stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive FIFO at the data address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A bench-side slave model records MOSI on every rising edge and serves MISO from a response queue. It checks the spacing of every SCLK edge and the total chip-select length against the divider. A three-byte write-only transfer at the fastest divider shows byte lane order, a partly used word and the absence of received data. A two-byte command followed by a five-byte read at a slower divider shows that the phases join without a gap, that MOSI stays low while reading, and that the final partial word is zero-padded and already present when busy drops. A 24-byte command, triggered with the FIFO preloaded and refilled while running, exercises the full flag, the dropped overflow word and the ignored mid-transfer transfer-word write. A soft reset in the middle of a read transaction checks that the engine and FIFOs are cleared while the configuration survives.

// File: rtl/spi_cmdread_master.sv
module spi_cmdread_master #(
  parameter int FIFO_AW = 2,
  parameter int DIV_RST = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam logic [2:0] A_CTRL = 3'd0, A_XFER = 3'd1, A_STAT = 3'd2,
                         A_IE = 3'd3, A_DIV = 3'd4, A_DATA = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LOW, S_HIGH, S_PUSH} st_t;
  st_t st;

  logic [7:0] div_q, ie_q, wfld, rfld;
  logic       mode_q;
  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [FIFO_AW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [7:0] cnt, tx_sh, rx_sh;
  logic [2:0] bitc;
  logic [8:0] wleft, rleft;
  logic [1:0] lane, rlane;
  logic       rd_ph;
  logic [31:0] rx_acc;

  wire tx_empty = tx_wp == tx_rp;
  wire rx_empty = rx_wp == rx_rp;
  wire tx_full  = (tx_wp[FIFO_AW] != tx_rp[FIFO_AW]) &&
                  (tx_wp[FIFO_AW-1:0] == tx_rp[FIFO_AW-1:0]);
  wire rx_full  = (rx_wp[FIFO_AW] != rx_rp[FIFO_AW]) &&
                  (rx_wp[FIFO_AW-1:0] == rx_rp[FIFO_AW-1:0]);
  wire busy     = st != S_IDLE;

  wire srst    = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  wire xfer_wr = reg_wr && reg_addr == A_XFER && !busy;
  wire start   = xfer_wr && reg_wdata[31];
  wire wr_data = reg_wr && reg_addr == A_DATA && !tx_full;
  wire rd_data = reg_rd && reg_addr == A_DATA && !rx_empty;

  wire tick = cnt >= div_q;
  wire eob  = st == S_HIGH && tick && bitc == 3'd7;
  wire [31:0] tx_head = tx_mem[tx_rp[FIFO_AW-1:0]];
  wire [7:0]  head_byte = 8'(tx_head >> {lane, 3'b000});

  wire fetch_ld = st == S_LOAD && !tx_empty;
  wire fetch_nx = eob && !rd_ph && wleft > 9'd1 && !tx_empty;
  wire tx_pop   = (fetch_ld && (lane == 2'd3 || wleft == 9'd1)) ||
                  (fetch_nx && (lane == 2'd3 || wleft == 9'd2));

  wire [31:0] rx_word = rx_acc | (32'(rx_sh) << {rlane, 3'b000});
  wire word_done = eob && rd_ph && (rlane == 2'd3 || rleft == 9'd1);
  wire rx_push   = (word_done || st == S_PUSH) && !rx_full;
  wire [31:0] rx_in = (st == S_PUSH) ? rx_acc : rx_word;

  assign sclk = st == S_HIGH;
  assign cs_n = st == S_IDLE;
  assign mosi = (st == S_LOW || st == S_HIGH) && !rd_ph && tx_sh[7];

  always_comb begin
    case (reg_addr)
      A_XFER:  reg_rdata = {15'd0, mode_q, rfld, wfld};
      A_STAT:  reg_rdata = {28'd0, tx_empty, rx_empty, tx_full, busy};
      A_IE:    reg_rdata = {24'd0, ie_q};
      A_DIV:   reg_rdata = {24'd0, div_q};
      A_DATA:  reg_rdata = rx_empty ? 32'd0 : rx_mem[rx_rp[FIFO_AW-1:0]];
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 8'(DIV_RST); ie_q <= '0; wfld <= '0; rfld <= '0; mode_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_IE)  ie_q <= reg_wdata[7:0];
      if (xfer_wr) begin
        wfld <= reg_wdata[7:0]; rfld <= reg_wdata[15:8]; mode_q <= reg_wdata[16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_data) tx_mem[tx_wp[FIFO_AW-1:0]] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp[FIFO_AW-1:0]] <= rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else if (srst) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (wr_data) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rd_data) rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitc <= '0; tx_sh <= '0; rx_sh <= '0;
      wleft <= '0; rleft <= '0; lane <= '0; rlane <= '0; rd_ph <= 1'b0; rx_acc <= '0;
    end else if (srst) begin
      st <= S_IDLE; cnt <= '0; bitc <= '0; rd_ph <= 1'b0; rx_acc <= '0;
      wleft <= '0; rleft <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wleft  <= {1'b0, reg_wdata[7:0]} + 9'd1;
          rleft  <= reg_wdata[16] ? {1'b0, reg_wdata[15:8]} + 9'd1 : 9'd0;
          rd_ph  <= 1'b0; lane <= '0; rlane <= '0; rx_acc <= '0; bitc <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: if (!tx_empty) begin
          tx_sh <= head_byte; lane <= lane + 2'd1; cnt <= '0; st <= S_LOW;
        end
        S_LOW: if (tick) begin
          cnt <= '0; rx_sh <= {rx_sh[6:0], miso}; st <= S_HIGH;
        end else cnt <= cnt + 8'd1;
        S_HIGH: if (!tick) cnt <= cnt + 8'd1;
        else begin
          cnt <= '0;
          if (bitc != 3'd7) begin
            bitc <= bitc + 3'd1; tx_sh <= {tx_sh[6:0], 1'b0}; st <= S_LOW;
          end else begin
            bitc <= '0;
            if (!rd_ph) begin
              wleft <= wleft - 9'd1;
              if (wleft > 9'd1) begin
                if (!tx_empty) begin
                  tx_sh <= head_byte; lane <= lane + 2'd1; st <= S_LOW;
                end else st <= S_LOAD;
              end else if (rleft != 9'd0) begin
                rd_ph <= 1'b1; st <= S_LOW;
              end else st <= S_IDLE;
            end else begin
              rleft <= rleft - 9'd1; rlane <= rlane + 2'd1;
              if (word_done) begin
                if (rx_full) begin
                  rx_acc <= rx_word; st <= S_PUSH;
                end else begin
                  rx_acc <= '0; st <= (rleft == 9'd1) ? S_IDLE : S_LOW;
                end
              end else begin
                rx_acc <= rx_word; st <= S_LOW;
              end
            end
          end
        end
        S_PUSH: if (!rx_full) begin
          rx_acc <= '0; cnt <= '0; st <= (rleft == 9'd0) ? S_IDLE : S_LOW;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_LOW || st == S_HIGH) && !tick && !srst) |=> st == $past(st));
  a_r4_read_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ph) |-> (st == S_LOW && cnt == 8'd0));
  a_r6_busy_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(rd_ph) && !$past(srst)) |-> !rx_empty);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && reg_wr && reg_addr == A_DATA && !tx_pop) |=> (tx_wp == $past(tx_wp)));
  a_r8_xfer_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == A_XFER) |=> ($stable(wfld) && $stable(rfld) && $stable(mode_q)));
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cs_n && tx_empty && rx_empty));
endmodule

// File: tb/spi_cmdread_master_tb.sv
module spi_cmdread_master_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, miso = 1'b0;
  logic [31:0] wdata = '0;
  wire [31:0] rdata;
  wire sclk, cs_n, mosi;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmdread_master dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso));

  // slave model state
  logic [7:0] resp[$];
  logic [7:0] cap_q[$];
  logic [7:0] exp_tx[$];
  logic [7:0] cur = '0;
  int wbits = 0, k = 0, cyc = 0, last_chg = -1, gap_bad = 0, mosi_bad = 0;
  int low_cyc = 0, dur = 0, idle_bad = 0, div_m = 1;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  function automatic logic mbit(int b);
    int i;
    if (b < wbits) return 1'b1;
    i = (b - wbits) / 8;
    if (i >= resp.size()) return 1'b0;
    return resp[i][7 - ((b - wbits) % 8)];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      k = 0; cap_q.delete(); low_cyc = 0; last_chg = -1; gap_bad = 0; mosi_bad = 0;
      miso = mbit(0);
    end
    if (!cs_n) low_cyc++;
    if (sclk !== prev_sclk) begin
      if (last_chg >= 0 && cyc - last_chg != div_m + 1) gap_bad++;
      last_chg = cyc;
    end
    if (!prev_sclk && sclk) begin
      if (k < wbits) begin
        cur = {cur[6:0], mosi};
        if (k % 8 == 7) cap_q.push_back(cur);
      end else if (mosi) mosi_bad++;
      k++;
      miso = mbit(k);
    end
    if (!prev_cs && cs_n) dur = low_cyc;
    if (cs_n && sclk) idle_bad++;
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    for (int i = 0; i < 20000; i++) begin
      rd_reg(3'd2, st);
      if (!st[0]) return;
    end
  endtask

  task automatic check_wire(string req, int nw, int nr);
    int bad = 0;
    if (cap_q.size() != exp_tx.size()) bad++;
    else for (int i = 0; i < exp_tx.size(); i++) if (cap_q[i] !== exp_tx[i]) bad++;
    chk({req, " R3 command bytes"}, 32'(bad), 32'd0);
    chk({req, " R1 edge spacing"}, 32'(gap_bad), 32'd0);
    chk({req, " R4 mosi low in read"}, 32'(mosi_bad), 32'd0);
    chk({req, " R4 cs length"}, 32'(dur), 32'(1 + 16 * (div_m + 1) * (nw + nr)));
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset values
    rd_reg(3'd2, v); chk("R11 status reset", v, 32'hC);
    rd_reg(3'd1, v); chk("R11 xfer reset", v, 32'h0);
    rd_reg(3'd4, v); chk("R1 divider reset", v, 32'h1);
    rd_reg(3'd3, v); chk("R11 ie reset", v, 32'h0);
    wr_reg(3'd3, 32'hFFFF_FF5A); rd_reg(3'd3, v); chk("R11 ie storage", v, 32'h5A);
    rd_reg(3'd5, v); chk("R5 empty read", v, 32'h0);

    // T1: write-only, 3 bytes, divider 0
    wr_reg(3'd4, 32'h1234_5600); div_m = 0;
    rd_reg(3'd4, v); chk("R1 divider upper bits", v, 32'h0);
    exp_tx = '{8'hAA, 8'hBB, 8'hCC}; resp.delete(); wbits = 24;
    wr_reg(3'd5, 32'h00CC_BBAA);
    wr_reg(3'd1, 32'h8000_0002);
    wait_idle(v);
    chk("R12 rx empty after write-only", v, 32'hC);
    check_wire("T1", 3, 0);
    rd_reg(3'd1, v); chk("R2 trigger reads 0", v, 32'h0000_0002);

    // T2: write-then-read, 2 cmd + 5 resp, divider 2
    wr_reg(3'd4, 32'hABCD_EF02); div_m = 2;
    rd_reg(3'd4, v); chk("R1 divider write", v, 32'h02);
    exp_tx = '{8'h9F, 8'h03}; resp = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hE5}; wbits = 16;
    wr_reg(3'd5, 32'hFFFF_039F);
    wr_reg(3'd1, 32'h8001_0401);
    wait_idle(v);
    chk("R6 rx ready when busy drops", v & 32'h5, 32'h0);
    check_wire("T2", 2, 5);
    rd_reg(3'd5, v); chk("R5 word0", v, 32'h4433_2211);
    rd_reg(3'd5, v); chk("R5 padded word1", v, 32'h0000_00E5);
    rd_reg(3'd5, v); chk("R5 empty after drain", v, 32'h0);

    // T3: 24-byte command, refill during run, divider 3
    wr_reg(3'd4, 32'h3); div_m = 3; resp.delete(); wbits = 192;
    exp_tx.delete();
    for (int w = 0; w < 6; w++)
      for (int b = 0; b < 4; b++) exp_tx.push_back(8'(16 * w + b + 1));
    for (int w = 0; w < 4; w++)
      wr_reg(3'd5, {exp_tx[4*w+3], exp_tx[4*w+2], exp_tx[4*w+1], exp_tx[4*w]});
    rd_reg(3'd2, v); chk("R6 tx full flag", v, 32'h6);
    wr_reg(3'd5, 32'hDEAD_BEEF); // R7 dropped
    wr_reg(3'd1, 32'h8000_0017);
    wr_reg(3'd1, 32'h8001_0303); // R8 ignored while busy
    for (int w = 4; w < 6; w++) begin
      do rd_reg(3'd2, v); while (v[1]);
      wr_reg(3'd5, {exp_tx[4*w+3], exp_tx[4*w+2], exp_tx[4*w+1], exp_tx[4*w]});
    end
    wait_idle(v);
    check_wire("T3 R7 R10", 24, 0);
    rd_reg(3'd1, v); chk("R8 xfer unchanged", v, 32'h0000_0017);

    // T4: soft reset mid read transaction
    resp = '{8'h5A, 8'hA5, 8'h0F, 8'hF0, 8'h33, 8'hCC, 8'h12, 8'h34}; wbits = 8;
    wr_reg(3'd5, 32'h0000_0077);
    wr_reg(3'd1, 32'h8001_0700);
    repeat (120) @(posedge clk);
    wr_reg(3'd0, 32'h1);
    @(negedge clk); chk("R9 cs released", 32'(cs_n), 32'd1);
    rd_reg(3'd2, v); chk("R9 status after soft reset", v, 32'hC);
    rd_reg(3'd4, v); chk("R9 divider kept", v, 32'h3);
    rd_reg(3'd5, v); chk("R9 rx flushed", v, 32'h0);
    chk("R3 sclk idle low", 32'(idle_bad), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule